// File: doc/BRIEF.md
# Byte-Lane Data Bus Inversion Codec

This block encodes and decodes data bus inversion on a memory data bus of one or more byte lanes. Each lane has one active-low inversion flag. On the write path, each byte is checked for how many zero bits it carries. A byte with too many zeros is sent inverted, and its flag is pulled low. The rule is that no beat drives more than four of the nine lines of a lane low, and the flag itself counts as one of those lines. On the read path, a byte whose flag arrives low is inverted back to its original value.

Each direction registers its result once, so results appear one clock after the beat is presented. Each direction has its own mode-style enable. Data masking uses the same pin as the write flag, so write inversion gives way when masking is enabled, and a configuration-error output is raised. A narrow (4-bit) device setting turns inversion off in both directions.

Top module: `dbi_codec`

## Requirements
- R1: While reset is asserted and on the first cycle after it, both output data buses are 0, every write flag is 1, both output valids are 0 and `cfg_err` is 0.
- R2: With write inversion active, a lane byte holding more than four zero bits is driven inverted on `tx_out_data` one clock later, and its flag bit in `tx_out_flag_n` is 0.
- R3: With write inversion active, a lane byte holding four or fewer zero bits is driven unchanged one clock later, and its flag bit is 1.
- R4: With write inversion active, each lane drives at most four zeros across its eight data bits plus its flag.
- R5: Lane i occupies data bits [8i+7:8i] and flag bit i. Each lane decides on its own, independent of the other lanes.
- R6: With `cfg_wr_inv_en` at 0, write data passes unchanged one clock later and all write flags are 1.
- R7: When `cfg_wr_inv_en` and `cfg_mask_en` are both 1, `cfg_err` is 1 one clock later and write data passes unchanged with flags at 1. The read path is not affected by `cfg_mask_en`.
- R8: With `cfg_rd_inv_en` at 1, a lane whose `rx_flag_n` bit is 0 is inverted on `rx_out_data` one clock later. A lane whose flag bit is 1 passes unchanged.
- R9: With `cfg_rd_inv_en` at 0, read data passes unchanged one clock later, whatever the flags are.
- R10: With `cfg_narrow` at 1, both directions pass data unchanged and all write flags are 1.
- R11: `tx_out_valid` and `rx_out_valid` follow `tx_valid` and `rx_valid` with one clock of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_narrow | input | 1 | Narrow (4-bit) device setting; turns inversion off |
| cfg_wr_inv_en | input | 1 | Write inversion enable |
| cfg_rd_inv_en | input | 1 | Read inversion enable |
| cfg_mask_en | input | 1 | Data masking enable; takes the shared pin from write inversion |
| tx_valid | input | 1 | Write beat present |
| tx_data | input | 8*LANES | Write beat from the controller |
| tx_out_valid | output | 1 | Encoded write beat present |
| tx_out_data | output | 8*LANES | Encoded write beat |
| tx_out_flag_n | output | LANES | Active-low inversion flag for each lane |
| rx_valid | input | 1 | Read beat present |
| rx_data | input | 8*LANES | Read beat from the bus |
| rx_flag_n | input | LANES | Received active-low flag for each lane |
| rx_out_valid | output | 1 | Decoded read beat present |
| rx_out_data | output | 8*LANES | Decoded read beat |
| cfg_err | output | 1 | Write inversion and masking both requested |

## Verification
The hardest cases to reach are at the decision boundary. The stimulus sends bytes with exactly four and exactly five zeros, and gives the two lanes opposite decisions in the same beat. The configuration conflict is also subtle. With masking and write inversion both on, an all-zero write byte must pass unchanged while a read beat in the same cycle is still decoded. The table puts both directions in every row, so each configuration row checks the two paths together.

// File: rtl/dbi_pkg.sv
package dbi_pkg;
  localparam int LANE_BITS = 8;
  localparam int MAX_LOW   = (LANE_BITS + 1) / 2;

  function automatic logic [3:0] count_zeros(input logic [LANE_BITS-1:0] b);
    logic [3:0] n;
    n = '0;
    for (int k = 0; k < LANE_BITS; k++) begin
      if (!b[k]) n = n + 4'd1;
    end
    return n;
  endfunction

  function automatic logic wants_invert(input logic [LANE_BITS-1:0] b);
    return count_zeros(b) > 4'(MAX_LOW);
  endfunction
endpackage

// File: rtl/dbi_cfg_ctrl.sv
module dbi_cfg_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_narrow,
  input  logic cfg_wr_inv_en,
  input  logic cfg_rd_inv_en,
  input  logic cfg_mask_en,
  output logic wr_active,
  output logic rd_active,
  output logic cfg_err
);
  logic conflict;

  assign conflict  = cfg_wr_inv_en & cfg_mask_en;
  // masking owns the shared pin, so write inversion yields
  assign wr_active = cfg_wr_inv_en & ~cfg_mask_en & ~cfg_narrow;
  assign rd_active = cfg_rd_inv_en & ~cfg_narrow;

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_err <= 1'b0;
    else        cfg_err <= conflict;
  end
endmodule

// File: rtl/dbi_tx_lane.sv
module dbi_tx_lane
  import dbi_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [LANE_BITS-1:0] din,
  output logic [LANE_BITS-1:0] dout,
  output logic                 flag_n
);
  logic do_inv;

  assign do_inv = en & wants_invert(din);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout   <= '0;
      flag_n <= 1'b1;
    end else begin
      dout   <= do_inv ? ~din : din;
      flag_n <= ~do_inv;
    end
  end
endmodule

// File: rtl/dbi_rx_lane.sv
module dbi_rx_lane
  import dbi_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [LANE_BITS-1:0] din,
  input  logic                 flag_n,
  output logic [LANE_BITS-1:0] dout
);
  logic restore;

  assign restore = en & ~flag_n;

  always_ff @(posedge clk) begin
    if (!rst_n) dout <= '0;
    else        dout <= restore ? ~din : din;
  end
endmodule

// File: rtl/dbi_codec.sv
module dbi_codec
  import dbi_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_narrow,
  input  logic                       cfg_wr_inv_en,
  input  logic                       cfg_rd_inv_en,
  input  logic                       cfg_mask_en,
  input  logic                       tx_valid,
  input  logic [LANES*LANE_BITS-1:0] tx_data,
  output logic                       tx_out_valid,
  output logic [LANES*LANE_BITS-1:0] tx_out_data,
  output logic [LANES-1:0]           tx_out_flag_n,
  input  logic                       rx_valid,
  input  logic [LANES*LANE_BITS-1:0] rx_data,
  input  logic [LANES-1:0]           rx_flag_n,
  output logic                       rx_out_valid,
  output logic [LANES*LANE_BITS-1:0] rx_out_data,
  output logic                       cfg_err
);
  logic wr_active;
  logic rd_active;

  dbi_cfg_ctrl u_cfg (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_narrow    (cfg_narrow),
    .cfg_wr_inv_en (cfg_wr_inv_en),
    .cfg_rd_inv_en (cfg_rd_inv_en),
    .cfg_mask_en   (cfg_mask_en),
    .wr_active     (wr_active),
    .rd_active     (rd_active),
    .cfg_err       (cfg_err)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dbi_tx_lane u_tx (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (wr_active),
      .din    (tx_data[g*LANE_BITS +: LANE_BITS]),
      .dout   (tx_out_data[g*LANE_BITS +: LANE_BITS]),
      .flag_n (tx_out_flag_n[g])
    );
    dbi_rx_lane u_rx (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (rd_active),
      .din    (rx_data[g*LANE_BITS +: LANE_BITS]),
      .flag_n (rx_flag_n[g]),
      .dout   (rx_out_data[g*LANE_BITS +: LANE_BITS])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_out_valid <= 1'b0;
      rx_out_valid <= 1'b0;
    end else begin
      tx_out_valid <= tx_valid;
      rx_out_valid <= rx_valid;
    end
  end
endmodule

// File: rtl/dbi_codec_checker.sv
module dbi_codec_checker #(
  parameter int LANES = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_narrow,
  input logic               cfg_wr_inv_en,
  input logic               cfg_rd_inv_en,
  input logic               cfg_mask_en,
  input logic               tx_valid,
  input logic [LANES*8-1:0] tx_data,
  input logic               tx_out_valid,
  input logic [LANES*8-1:0] tx_out_data,
  input logic [LANES-1:0]   tx_out_flag_n,
  input logic               rx_valid,
  input logic [LANES*8-1:0] rx_data,
  input logic [LANES-1:0]   rx_flag_n,
  input logic               rx_out_valid,
  input logic [LANES*8-1:0] rx_out_data,
  input logic               cfg_err
);
  logic wr_on;
  logic rd_on;
  assign wr_on = cfg_wr_inv_en && !cfg_mask_en && !cfg_narrow;
  assign rd_on = cfg_rd_inv_en && !cfg_narrow;

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    // R4: at least five of the nine lines stay high
    a_r4_low_budget: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(wr_on)) |->
        ($countones({tx_out_data[g*8 +: 8], tx_out_flag_n[g]}) >= 5));
    // R2, R3: decoding with the flag recovers the beat that was sent
    a_r2_round_trip: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |->
        ((tx_out_data[g*8 +: 8] ^ {8{!tx_out_flag_n[g]}}) == $past(tx_data[g*8 +: 8])));
    // R8: a low received flag inverts the lane when reading is enabled
    a_r8_rx_restore: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(rd_on) && !$past(rx_flag_n[g])) |->
        (rx_out_data[g*8 +: 8] == ~$past(rx_data[g*8 +: 8])));
  end

  // R6, R7, R10: write path idle keeps every flag high
  a_r6_flags_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(wr_on)) |-> (&tx_out_flag_n));
  // R9: disabled read path is transparent
  a_r9_rx_pass: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(rd_on)) |-> (rx_out_data == $past(rx_data)));
  // R7: conflict flag follows the requested combination
  a_r7_conflict: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (cfg_err == $past(cfg_wr_inv_en && cfg_mask_en)));
  // R11: valids lag their inputs by one clock
  a_r11_valid_lag: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (tx_out_valid == $past(tx_valid) && rx_out_valid == $past(rx_valid)));
endmodule

bind dbi_codec dbi_codec_checker #(.LANES(LANES)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_narrow    (cfg_narrow),
  .cfg_wr_inv_en (cfg_wr_inv_en),
  .cfg_rd_inv_en (cfg_rd_inv_en),
  .cfg_mask_en   (cfg_mask_en),
  .tx_valid      (tx_valid),
  .tx_data       (tx_data),
  .tx_out_valid  (tx_out_valid),
  .tx_out_data   (tx_out_data),
  .tx_out_flag_n (tx_out_flag_n),
  .rx_valid      (rx_valid),
  .rx_data       (rx_data),
  .rx_flag_n     (rx_flag_n),
  .rx_out_valid  (rx_out_valid),
  .rx_out_data   (rx_out_data),
  .cfg_err       (cfg_err)
);

// File: tb/dbi_codec_bench.sv
`timescale 1ns/1ps
module dbi_codec_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_narrow = 1'b0, cfg_wr_inv_en = 1'b0, cfg_rd_inv_en = 1'b0, cfg_mask_en = 1'b0;
  logic        tx_valid = 1'b0, rx_valid = 1'b0;
  logic [15:0] tx_data = '0, rx_data = '0;
  logic [1:0]  rx_flag_n = 2'b11;
  logic        tx_out_valid, rx_out_valid, cfg_err;
  logic [15:0] tx_out_data, rx_out_data;
  logic [1:0]  tx_out_flag_n;
  int          n_checks = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  dbi_codec #(.LANES(2)) u_dbi_codec (
    .clk(clk), .rst_n(rst_n), .cfg_narrow(cfg_narrow), .cfg_wr_inv_en(cfg_wr_inv_en),
    .cfg_rd_inv_en(cfg_rd_inv_en), .cfg_mask_en(cfg_mask_en), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_out_valid(tx_out_valid), .tx_out_data(tx_out_data),
    .tx_out_flag_n(tx_out_flag_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_flag_n(rx_flag_n), .rx_out_valid(rx_out_valid), .rx_out_data(rx_out_data),
    .cfg_err(cfg_err)
  );

  // cfg = {narrow, wr, rd, mask}
  typedef struct packed {
    logic [3:0]  cfg;
    logic [15:0] txd;
    logic [15:0] rxd;
    logic [1:0]  rxf;
    logic [15:0] exp_txd;
    logic [1:0]  exp_txf;
    logic [15:0] exp_rxd;
    logic        exp_err;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    {4'b0110, 16'h00FF, 16'h1234, 2'b10, 16'hFFFF, 2'b01, 16'h12CB, 1'b0, 4'd2},
    {4'b0110, 16'h0F01, 16'hA5A5, 2'b11, 16'h0FFE, 2'b10, 16'hA5A5, 1'b0, 4'd3},
    {4'b0110, 16'h1003, 16'h00FF, 2'b00, 16'hEFFC, 2'b00, 16'hFF00, 1'b0, 4'd5},
    {4'b0110, 16'h3807, 16'hF00F, 2'b01, 16'hC7F8, 2'b00, 16'h0F0F, 1'b0, 4'd4},
    {4'b0110, 16'hF0E1, 16'h0000, 2'b11, 16'hF0E1, 2'b11, 16'h0000, 1'b0, 4'd3},
    {4'b0010, 16'h0000, 16'h0000, 2'b00, 16'h0000, 2'b11, 16'hFFFF, 1'b0, 4'd6},
    {4'b0100, 16'h0000, 16'h5A5A, 2'b00, 16'hFFFF, 2'b00, 16'h5A5A, 1'b0, 4'd9},
    {4'b0111, 16'h0000, 16'h00FF, 2'b01, 16'h0000, 2'b11, 16'hFFFF, 1'b1, 4'd7},
    {4'b0011, 16'h0102, 16'h3C3C, 2'b11, 16'h0102, 2'b11, 16'h3C3C, 1'b0, 4'd7},
    {4'b1110, 16'h0000, 16'h000A, 2'b00, 16'h0000, 2'b11, 16'h000A, 1'b0, 4'd10}
  };

  function automatic string tag(input logic [3:0] r);
    case (r)
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd9:    return "R9";
      4'd10:   return "R10";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [15:0] act,
                       input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_reset_state();
    check("R1", "tx_out_data", tx_out_data, 16'h0000);
    check("R1", "tx_out_flag_n", {14'd0, tx_out_flag_n}, 16'h0003);
    check("R1", "rx_out_data", rx_out_data, 16'h0000);
    check("R1", "valids", {14'd0, tx_out_valid, rx_out_valid}, 16'h0000);
    check("R1", "cfg_err", {15'd0, cfg_err}, 16'h0000);
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_reset_state();             // R1 during reset
    rst_n = 1'b1;
    @(negedge clk);
    check_reset_state();             // R1 first cycle after release

    for (int i = 0; i < NV; i++) begin
      {cfg_narrow, cfg_wr_inv_en, cfg_rd_inv_en, cfg_mask_en} = VEC[i].cfg;
      tx_data   = VEC[i].txd;
      rx_data   = VEC[i].rxd;
      rx_flag_n = VEC[i].rxf;
      tx_valid  = i[0];
      rx_valid  = ~i[0];
      @(negedge clk);
      check(tag(VEC[i].req), "tx_out_data", tx_out_data, VEC[i].exp_txd);
      check(tag(VEC[i].req), "tx_out_flag_n", {14'd0, tx_out_flag_n}, {14'd0, VEC[i].exp_txf});
      check((VEC[i].req == 4'd9) ? "R9" : "R8", "rx_out_data", rx_out_data, VEC[i].exp_rxd);
      check("R7", "cfg_err", {15'd0, cfg_err}, {15'd0, VEC[i].exp_err});
      check("R11", "valids", {14'd0, tx_out_valid, rx_out_valid}, {14'd0, i[0], ~i[0]});
    end

    // R8: read decode with write path masked off, mixed flags
    {cfg_narrow, cfg_wr_inv_en, cfg_rd_inv_en, cfg_mask_en} = 4'b0011;
    rx_data = 16'h8001; rx_flag_n = 2'b01;
    @(negedge clk);
    check("R8", "rx_out_data mixed", rx_out_data, 16'h7F01);

    // R1: reset in mid-run clears everything
    rst_n = 1'b0;
    @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule